// File: doc/BRIEF.md
# Lockstep Bus Divergence Checker

Two redundant processing channels run the same program in lockstep. Where their outputs come together to feed one recipient, this block watches three buses: peripheral, flash and SRAM. On each bus, channel A's request goes downstream unchanged and with no delay. Channel B's copy of the same request is used only for comparison. When the two copies disagree, the block does not stop the request. It flags the divergence instead.

For each bus, a divergence gives a one-cycle error pulse on the clock edge after the cycle in which it is seen. It also sets a per-bus sticky status bit, which only reset clears. A combined fault line ORs the per-bus pulses and feeds a separate fault-collection unit, which decides how the system reacts.

A mode input selects between lockstep operation and decoupled operation, in which the cores run independently. The control state machine reads this input once, on the first clock edge after reset is released. It then stays in the chosen state until the next reset.

The control state machine has three states:
- `MS_SAMPLE` is entered on reset. Checking is off in this state.
- `MS_LOCKSTEP` is entered from `MS_SAMPLE` when the decoupled input is 0 (transition *pick_lockstep*). Checking is on in this state.
- `MS_DECOUPLED` is entered from `MS_SAMPLE` when the decoupled input is 1 (transition *pick_decoupled*). Checking is off in this state.

Both run states hold themselves (transition *hold*). Only reset returns the machine to `MS_SAMPLE`.

Top module: `lockstep_out_checker`

## Requirements
- R1: On every bus, the downstream outputs (valid, address, write, byte enables, write data) equal channel A's inputs in the same cycle. This holds whatever channel B drives and whatever the mode.
- R2: In lockstep mode, with both valids 1, a difference in address, write direction (1 = write, 0 = read) or byte enables raises that bus's error bit in the cycle after the difference. The other buses are unaffected.
- R3: Write data is compared only when channel A's write bit is 1. For a read with differing write data and all other fields equal, no error is raised.
- R4: In lockstep mode, a cycle in which exactly one channel's valid is 1 raises that bus's error.
- R5: When both valids are 0, differences in the other fields raise no error.
- R6: Each bus has a sticky status bit (bit i is bus i: 0 peripheral, 1 flash, 2 SRAM). The bit is set by that bus's error and stays set until reset.
- R7: In decoupled mode, no error, sticky bit or fault is ever raised.
- R8: The mode is taken from the decoupled input on the first rising edge after reset is released. No check occurs in that cycle. Later changes of the input have no effect until the next reset.
- R9: Each error bit is high for exactly one cycle per diverging cycle. The fault output is high whenever any error bit is high.
- R10: While reset is asserted, and right after it, the error bits, sticky bits and fault output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decoupled_i | input | 1 | 1 selects decoupled mode; read at the first edge after reset |
| a_valid_i | input | NBUS | Channel A request valid, per bus |
| a_addr_i | input | NBUS×ADDR_W | Channel A address |
| a_write_i | input | NBUS | Channel A direction (1 = write) |
| a_be_i | input | NBUS×DATA_W/8 | Channel A byte enables |
| a_wdata_i | input | NBUS×DATA_W | Channel A write data |
| b_valid_i | input | NBUS | Channel B request valid |
| b_addr_i | input | NBUS×ADDR_W | Channel B address |
| b_write_i | input | NBUS | Channel B direction |
| b_be_i | input | NBUS×DATA_W/8 | Channel B byte enables |
| b_wdata_i | input | NBUS×DATA_W | Channel B write data |
| dn_valid_o | output | NBUS | Downstream valid (channel A) |
| dn_addr_o | output | NBUS×ADDR_W | Downstream address |
| dn_write_o | output | NBUS | Downstream direction |
| dn_be_o | output | NBUS×DATA_W/8 | Downstream byte enables |
| dn_wdata_o | output | NBUS×DATA_W | Downstream write data |
| err_o | output | NBUS | One-cycle divergence pulse, per bus |
| sticky_o | output | NBUS | Sticky divergence status, per bus |
| fault_o | output | 1 | OR of the error pulses, to fault collection |

## Verification
The assertions assume that both channels' inputs are stable and known at each rising edge. They also assume that the decoupled input settles before the first edge after reset, so that the sampled mode is well defined.

The bench meets these assumptions in three ways. It changes every input only on the falling edge. It holds the mode input steady through reset and the sampling edge. It sends no request in the sampling cycle. Only after the mode is latched does it change the mode input on purpose, to show that the change is ignored.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
package lsc_pkg;

    typedef enum logic [1:0] {
        MS_SAMPLE    = 2'd0,
        MS_LOCKSTEP  = 2'd1,
        MS_DECOUPLED = 2'd2
    } mode_state_e;

endpackage

// File: rtl/lsc_mode_ctrl.sv
`timescale 1ns/1ps
module lsc_mode_ctrl
    import lsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        decoupled_i,
    output logic        chk_en_o,
    output mode_state_e state_o
);

    mode_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_SAMPLE:    state_d = decoupled_i ? MS_DECOUPLED : MS_LOCKSTEP;
            MS_LOCKSTEP:  state_d = MS_LOCKSTEP;
            MS_DECOUPLED: state_d = MS_DECOUPLED;
            default:      state_d = MS_SAMPLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_SAMPLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        chk_en_o = 1'b0;
        unique case (state_q)
            MS_LOCKSTEP:  chk_en_o = 1'b1;
            MS_SAMPLE,
            MS_DECOUPLED: chk_en_o = 1'b0;
            default:      chk_en_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/lsc_bus_cmp.sv
`timescale 1ns/1ps
module lsc_bus_cmp #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en_i,
    input  logic              a_valid_i,
    input  logic [ADDR_W-1:0] a_addr_i,
    input  logic              a_write_i,
    input  logic [BE_W-1:0]   a_be_i,
    input  logic [DATA_W-1:0] a_wdata_i,
    input  logic              b_valid_i,
    input  logic [ADDR_W-1:0] b_addr_i,
    input  logic              b_write_i,
    input  logic [BE_W-1:0]   b_be_i,
    input  logic [DATA_W-1:0] b_wdata_i,
    output logic              err_o,
    output logic              sticky_o
);

    logic valid_diff;
    logic ctl_diff;
    logic data_diff;
    logic diverge;
    logic err_q, sticky_q;

    always_comb begin
        valid_diff = (a_valid_i != b_valid_i);
        ctl_diff   = (a_addr_i != b_addr_i) || (a_write_i != b_write_i)
                   || (a_be_i != b_be_i);
        data_diff  = a_write_i && (a_wdata_i != b_wdata_i);
        diverge    = chk_en_i
                   && (valid_diff || (a_valid_i && (ctl_diff || data_diff)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            err_q    <= diverge;
            sticky_q <= sticky_q | diverge;
        end
    end

    assign err_o    = err_q;
    assign sticky_o = sticky_q;

endmodule

// File: rtl/lockstep_out_checker.sv
`timescale 1ns/1ps
module lockstep_out_checker
    import lsc_pkg::*;
#(
    parameter int NBUS   = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              decoupled_i,
    input  logic [NBUS-1:0]                   a_valid_i,
    input  logic [NBUS-1:0][ADDR_W-1:0]       a_addr_i,
    input  logic [NBUS-1:0]                   a_write_i,
    input  logic [NBUS-1:0][DATA_W/8-1:0]     a_be_i,
    input  logic [NBUS-1:0][DATA_W-1:0]       a_wdata_i,
    input  logic [NBUS-1:0]                   b_valid_i,
    input  logic [NBUS-1:0][ADDR_W-1:0]       b_addr_i,
    input  logic [NBUS-1:0]                   b_write_i,
    input  logic [NBUS-1:0][DATA_W/8-1:0]     b_be_i,
    input  logic [NBUS-1:0][DATA_W-1:0]       b_wdata_i,
    output logic [NBUS-1:0]                   dn_valid_o,
    output logic [NBUS-1:0][ADDR_W-1:0]       dn_addr_o,
    output logic [NBUS-1:0]                   dn_write_o,
    output logic [NBUS-1:0][DATA_W/8-1:0]     dn_be_o,
    output logic [NBUS-1:0][DATA_W-1:0]       dn_wdata_o,
    output logic [NBUS-1:0]                   err_o,
    output logic [NBUS-1:0]                   sticky_o,
    output logic                              fault_o
);

    localparam int BE_W = DATA_W / 8;

    logic        chk_en;
    mode_state_e mode_state;

    lsc_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .decoupled_i (decoupled_i),
        .chk_en_o    (chk_en),
        .state_o     (mode_state)
    );

    for (genvar g = 0; g < NBUS; g++) begin : g_bus
        // channel A is forwarded untouched
        assign dn_valid_o[g] = a_valid_i[g];
        assign dn_addr_o[g]  = a_addr_i[g];
        assign dn_write_o[g] = a_write_i[g];
        assign dn_be_o[g]    = a_be_i[g];
        assign dn_wdata_o[g] = a_wdata_i[g];

        lsc_bus_cmp #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .BE_W   (BE_W)
        ) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .chk_en_i  (chk_en),
            .a_valid_i (a_valid_i[g]),
            .a_addr_i  (a_addr_i[g]),
            .a_write_i (a_write_i[g]),
            .a_be_i    (a_be_i[g]),
            .a_wdata_i (a_wdata_i[g]),
            .b_valid_i (b_valid_i[g]),
            .b_addr_i  (b_addr_i[g]),
            .b_write_i (b_write_i[g]),
            .b_be_i    (b_be_i[g]),
            .b_wdata_i (b_wdata_i[g]),
            .err_o     (err_o[g]),
            .sticky_o  (sticky_o[g])
        );
    end

    assign fault_o = |err_o;

endmodule

// File: rtl/lsc_checker.sv
`timescale 1ns/1ps
module lsc_checker
    import lsc_pkg::*;
#(
    parameter int NBUS   = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          chk_en,
    input mode_state_e                   mode_state,
    input logic [NBUS-1:0]               a_valid_i,
    input logic [NBUS-1:0][ADDR_W-1:0]   a_addr_i,
    input logic [NBUS-1:0]               a_write_i,
    input logic [NBUS-1:0][DATA_W/8-1:0] a_be_i,
    input logic [NBUS-1:0][DATA_W-1:0]   a_wdata_i,
    input logic [NBUS-1:0]               b_valid_i,
    input logic [NBUS-1:0][ADDR_W-1:0]   b_addr_i,
    input logic [NBUS-1:0]               b_write_i,
    input logic [NBUS-1:0][DATA_W/8-1:0] b_be_i,
    input logic [NBUS-1:0]               dn_valid_o,
    input logic [NBUS-1:0][ADDR_W-1:0]   dn_addr_o,
    input logic [NBUS-1:0][DATA_W-1:0]   dn_wdata_o,
    input logic [NBUS-1:0]               err_o,
    input logic [NBUS-1:0]               sticky_o,
    input logic                          fault_o
);

    always_comb begin
        if (rst_n) begin
            assert_forward_a_R1: assert (dn_valid_o == a_valid_i
                && dn_addr_o == a_addr_i && dn_wdata_o == a_wdata_i);
        end
    end

    for (genvar g = 0; g < NBUS; g++) begin : g_chk
        assert_addr_diverge_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (chk_en && a_valid_i[g] && b_valid_i[g] && (a_addr_i[g] != b_addr_i[g]))
            |=> err_o[g]);

        assert_read_data_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid_i[g] && b_valid_i[g] && !a_write_i[g] && !b_write_i[g]
             && a_addr_i[g] == b_addr_i[g] && a_be_i[g] == b_be_i[g])
            |=> !err_o[g]);

        assert_valid_diverge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (chk_en && (a_valid_i[g] != b_valid_i[g])) |=> err_o[g]);

        assert_idle_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_valid_i[g] && !b_valid_i[g]) |=> !err_o[g]);

        assert_err_marks_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[g] |-> (sticky_o[g] && fault_o));
    end

    assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

    assert_decoupled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == MS_DECOUPLED) |-> (err_o == '0 && sticky_o == '0 && !fault_o));

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state != MS_SAMPLE) |=> $stable(mode_state));

endmodule

bind lockstep_out_checker lsc_checker #(
    .NBUS   (NBUS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (chk_en),
    .mode_state (mode_state),
    .a_valid_i  (a_valid_i),
    .a_addr_i   (a_addr_i),
    .a_write_i  (a_write_i),
    .a_be_i     (a_be_i),
    .a_wdata_i  (a_wdata_i),
    .b_valid_i  (b_valid_i),
    .b_addr_i   (b_addr_i),
    .b_write_i  (b_write_i),
    .b_be_i     (b_be_i),
    .dn_valid_o (dn_valid_o),
    .dn_addr_o  (dn_addr_o),
    .dn_wdata_o (dn_wdata_o),
    .err_o      (err_o),
    .sticky_o   (sticky_o),
    .fault_o    (fault_o)
);

// File: tb/lockstep_out_checker_tb.sv
`timescale 1ns/1ps
module lockstep_out_checker_tb;

    localparam int NBUS = 3;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int BW   = DW / 8;

    // vector: [5:4] bus, [3:1] kind, [0] expected error on that bus
    // kinds: 0 equal write, 1 addr diff, 2 dir diff, 3 be diff,
    //        4 wdata diff on write, 5 wdata diff on read, 6 only A valid,
    //        7 both idle with addr diff
    localparam int NVEC = 12;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_000_0, 6'b00_001_1, 6'b01_010_1, 6'b10_011_1,
        6'b01_100_1, 6'b10_101_0, 6'b00_110_1, 6'b01_111_0,
        6'b10_100_1, 6'b01_001_1, 6'b00_101_0, 6'b10_110_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic decoupled = 1'b0;
    logic [NBUS-1:0]         a_valid, b_valid, a_write, b_write;
    logic [NBUS-1:0][AW-1:0] a_addr, b_addr;
    logic [NBUS-1:0][BW-1:0] a_be, b_be;
    logic [NBUS-1:0][DW-1:0] a_wdata, b_wdata;
    logic [NBUS-1:0]         dn_valid, dn_write;
    logic [NBUS-1:0][AW-1:0] dn_addr;
    logic [NBUS-1:0][BW-1:0] dn_be;
    logic [NBUS-1:0][DW-1:0] dn_wdata;
    logic [NBUS-1:0]         err, sticky;
    logic                    fault;

    int checks = 0;
    int errors = 0;
    logic [NBUS-1:0] exp_sticky;

    always #2.5 clk = ~clk;

    lockstep_out_checker #(.NBUS(NBUS), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .decoupled_i(decoupled),
        .a_valid_i(a_valid), .a_addr_i(a_addr), .a_write_i(a_write),
        .a_be_i(a_be), .a_wdata_i(a_wdata),
        .b_valid_i(b_valid), .b_addr_i(b_addr), .b_write_i(b_write),
        .b_be_i(b_be), .b_wdata_i(b_wdata),
        .dn_valid_o(dn_valid), .dn_addr_o(dn_addr), .dn_write_o(dn_write),
        .dn_be_o(dn_be), .dn_wdata_o(dn_wdata),
        .err_o(err), .sticky_o(sticky), .fault_o(fault)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_same(input int seed, input logic wr);
        for (int b = 0; b < NBUS; b++) begin
            a_valid[b] = 1'b1;             b_valid[b] = 1'b1;
            a_addr[b]  = 32'h1000_0000 + 32'(seed * 64 + b * 4);
            b_addr[b]  = a_addr[b];
            a_write[b] = wr;               b_write[b] = wr;
            a_be[b]    = 4'hF;             b_be[b]    = 4'hF;
            a_wdata[b] = 32'hA5A5_0000 + 32'(seed * 8 + b);
            b_wdata[b] = a_wdata[b];
        end
    endtask

    task automatic drive_idle();
        a_valid = '0; b_valid = '0; a_write = '0; b_write = '0;
        a_addr = '0; b_addr = '0; a_be = '0; b_be = '0;
        a_wdata = '0; b_wdata = '0;
    endtask

    task automatic check_forward(input string req);
        check(req, 64'(dn_valid), 64'(a_valid));
        check(req, 64'(dn_addr[0] ^ dn_addr[1] ^ dn_addr[2] ^ {29'd0, dn_write}),
                   64'(a_addr[0] ^ a_addr[1] ^ a_addr[2] ^ {29'd0, a_write}));
        check(req, 64'({dn_be, dn_wdata[0] ^ dn_wdata[1] ^ dn_wdata[2]}),
                   64'({a_be, a_wdata[0] ^ a_wdata[1] ^ a_wdata[2]}));
    endtask

    // apply inputs already set, then sample the registered outputs after the edge
    task automatic clock_and_check(input string req, input logic [NBUS-1:0] exp_err);
        @(posedge clk);
        #1;
        exp_sticky = exp_sticky | exp_err;
        check(req, 64'(err), 64'(exp_err));
        check(req, 64'(sticky), 64'(exp_sticky));
        check(req, 64'(fault), 64'(|exp_err));
    endtask

    task automatic do_reset(input logic dec);
        @(negedge clk);
        rst_n = 1'b0;
        decoupled = dec;
        drive_idle();
        #1;
        check("R10 in reset", 64'({fault, sticky, err}), 64'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);        // mode sampling edge, no request
        #1;
        exp_sticky = '0;
        check("R10 after reset", 64'({fault, sticky, err}), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NBUS-1:0] e;
        drive_idle();
        exp_sticky = '0;
        do_reset(1'b0);

        // table walk: each kind on a chosen bus (R1..R6)
        for (int i = 0; i < NVEC; i++) begin
            int bsel;
            logic [2:0] kind;
            bsel = int'(VEC[i][5:4]);
            kind = VEC[i][3:1];
            @(negedge clk);
            drive_same(i, kind != 3'd5);
            unique case (kind)
                3'd1: b_addr[bsel]  = b_addr[bsel] ^ 32'h4;
                3'd2: b_write[bsel] = ~b_write[bsel];
                3'd3: b_be[bsel]    = 4'h3;
                3'd4: b_wdata[bsel] = b_wdata[bsel] ^ 32'h1;
                3'd5: b_wdata[bsel] = b_wdata[bsel] ^ 32'hFF;
                3'd6: b_valid[bsel] = 1'b0;
                3'd7: begin
                    a_valid[bsel] = 1'b0;
                    b_valid[bsel] = 1'b0;
                    b_addr[bsel]  = b_addr[bsel] ^ 32'h80;
                end
                default: ;
            endcase
            #1;
            check_forward("R1 forward A");
            e = '0;
            e[bsel] = VEC[i][0];
            clock_and_check("R2 R3 R4 R5 R6 table", e);
        end

        // R6: sticky bits stay set through idle cycles
        @(negedge clk);
        drive_idle();
        clock_and_check("R6 sticky hold", '0);
        clock_and_check("R6 sticky hold", '0);

        // R8: a mode input change after the sampling edge is ignored
        @(negedge clk);
        decoupled = 1'b1;
        drive_same(20, 1'b1);
        b_addr[0] = b_addr[0] ^ 32'h10;
        clock_and_check("R8 late mode change ignored", 3'b001);

        // R9: two diverging cycles give two pulses, then it drops
        @(negedge clk);
        drive_same(21, 1'b1);
        b_be[1] = 4'h1;
        clock_and_check("R9 pulse 1", 3'b010);
        @(negedge clk);
        b_be[1] = 4'h2;
        clock_and_check("R9 pulse 2", 3'b010);
        @(negedge clk);
        drive_same(22, 1'b1);
        clock_and_check("R9 drop", 3'b000);

        // R7: decoupled mode reports nothing, forwarding still works
        do_reset(1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive_same(30 + k, 1'b1);
            b_addr[k]  = ~a_addr[k];
            b_valid[(k + 1) % NBUS] = 1'b0;
            #1;
            check_forward("R1 forward in decoupled");
            clock_and_check("R7 decoupled silent", 3'b000);
        end
        @(negedge clk);
        decoupled = 1'b0;
        drive_same(40, 1'b1);
        b_write = ~a_write;
        clock_and_check("R8 stays decoupled", 3'b000);

        // R8/R2: new reset in lockstep mode re-enables checking
        do_reset(1'b0);
        @(negedge clk);
        drive_same(50, 1'b1);
        b_write[2] = 1'b0;
        clock_and_check("R2 R8 lockstep after reset", 3'b100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule